// File: doc/BRIEF.md
# Flash Write-Engine Busy Status and Block Lock Controller

This block is the control half of a parallel NOR flash write engine. A command decoder in front of it hands over already-decoded, single-cycle strobes (program, block erase, suspend, resume, lock one block, unlock all blocks, configure the status pin) together with a block index. The block keeps one lock flag per block and refuses program or erase work aimed at a locked block. Each accepted operation runs a timed busy phase whose length is a parameter. A small status word and a single status pin report progress to the host.

The status pin has two modes. In level mode it works as a ready/busy line. In pulse mode it stays high and drops for a short fixed pulse when a selected kind of operation completes, so a host can use it as an interrupt. Program and erase can be suspended and resumed, and the remaining time is kept across the suspension. An active-low reset/power-down input returns everything to idle. After that input is released, a short wake-up window follows in which commands are ignored.

Top module: `flash_wsm_ctrl`

## Requirements
- R1: A lock command sets the lock flag of the addressed block, and an unlock-all command clears every flag. Each takes effect when its busy phase ends. Reset clears all flags.
- R2: A program or erase aimed at a locked block does not start. The block stays ready and sets the lock-error flag, stat_o bit 2.
- R3: stat_o bit 0 (ready) is 0 exactly while an operation is running. Program runs PROG_CYC cycles, erase runs ERASE_CYC cycles and lock or unlock runs LOCK_CYC cycles. Both error flags (bits 2 and 3) are cleared when an operation starts.
- R4: In level mode, sts_o is low exactly while an operation is running and high otherwise.
- R5: An accepted suspend makes the block ready (bit 0 = 1), sets stat_o bit 1 (suspended) and, in level mode, drives sts_o high. A resume returns the block to the running state.
- R6: A configure command written while idle selects the status pin mode from cmd_cfg_mode: 0 = level, 1 = pulse on erase, 2 = pulse on program, 3 = pulse on either. In pulse mode, sts_o stays high while an operation runs.
- R7: While rst_n is low, the block is idle, stat_o reads 4'b0001, sts_o is high, the pin mode returns to level and no command is accepted.
- R8: For the first WAKE_CYC rising edges after rst_n goes high, every command is ignored. A command on the following edge is accepted.
- R9: In pulse mode, sts_o is low for exactly PULSE_CYC cycles, starting in the cycle after a selected program or erase completes. Lock and unlock operations never produce a pulse.
- R10: While an operation is suspended, its remaining time does not decrease.
- R11: A suspend is accepted only while a program or erase is running. A suspend or resume while idle is ignored and leaves the status unchanged. A suspend during a lock or unlock operation is refused as a sequence error.
- R12: Any command that arrives while an operation is running or suspended, other than an accepted suspend or resume, is ignored and sets the sequence-error flag, stat_o bit 3. The flag stays set until the next operation starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset / power-down, asynchronous assert |
| cmd_prog | input | 1 | Program strobe |
| cmd_erase | input | 1 | Block erase strobe |
| cmd_susp | input | 1 | Suspend strobe |
| cmd_resume | input | 1 | Resume strobe |
| cmd_lock | input | 1 | Lock-one-block strobe |
| cmd_unlock_all | input | 1 | Unlock-all-blocks strobe |
| cmd_cfg | input | 1 | Status-pin configuration strobe |
| cmd_blk | input | BLK_W | Block index for program, erase and lock |
| cmd_cfg_mode | input | 2 | Status pin mode written by cmd_cfg |
| sts_o | output | 1 | Status pin (level ready/busy or completion pulse) |
| stat_o | output | 4 | Status word: bit 3 sequence error, bit 2 lock error, bit 1 suspended, bit 0 ready |

## Verification
A stuck or mis-loaded duration counter shows up as a ready bit or level-mode pin that returns high on the wrong edge, which is visible on the first cycle the count differs. A wrong lock flag shows up on the next program or erase to that block: it either starts (ready drops) when it should be refused, or is refused with bit 2 set when it should start. A suspension that lets time leak, or a pulse counter of the wrong length, appears as a completion edge or a pin rising edge that is early or late by whole cycles. Sampling every vector on a known cycle catches each of these as soon as it appears.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_SUSP = 2'd2
  } fsm_e;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_ERASE = 2'd1,
    OP_LOCK  = 2'd2,
    OP_CLRLK = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    STS_LEVEL   = 2'd0,
    STS_P_ERASE = 2'd1,
    STS_P_PROG  = 2'd2,
    STS_P_BOTH  = 2'd3
  } sts_mode_e;

  typedef struct packed {
    logic seq_err;
    logic lock_err;
    logic suspended;
    logic ready;
  } stat_t;

  // duration of an operation in cycles
  function automatic int unsigned op_len(op_e k, int unsigned p_cyc,
                                         int unsigned e_cyc, int unsigned l_cyc);
    case (k)
      OP_PROG:  return p_cyc;
      OP_ERASE: return e_cyc;
      default:  return l_cyc;
    endcase
  endfunction

  // whether a completing operation of kind k pulses the pin in mode m
  function automatic logic wants_pulse(sts_mode_e m, op_e k);
    return ((k == OP_PROG) && m[1]) || ((k == OP_ERASE) && m[0]);
  endfunction

  function automatic logic can_suspend(op_e k);
    return (k == OP_PROG) || (k == OP_ERASE);
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/fwc_lock_bank.sv
module fwc_lock_bank #(
  parameter int NBLK  = 8,
  parameter int BLK_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [BLK_W-1:0] set_idx,
  input  logic             clr_all,
  input  logic [BLK_W-1:0] rd_idx,
  output logic             rd_locked
);

  logic [NBLK-1:0] lk_q;

  for (genvar g = 0; g < NBLK; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    lk_q[g] <= 1'b0;
      else if (clr_all)                              lk_q[g] <= 1'b0;
      else if (set_en && (set_idx == BLK_W'(g)))     lk_q[g] <= 1'b1;
    end
  end

  assign rd_locked = lk_q[rd_idx];

  // R1: an unlock-all completion leaves no flag set
  assert_clear_all_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (lk_q == '0));

  // R1: a lock completion leaves the chosen flag set
  assert_set_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_all) |=> lk_q[$past(set_idx)]);

endmodule

// File: rtl/fwc_op_timer.sv
module fwc_op_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (load)                    cnt_q <= load_val;
    else if (run && (cnt_q != '0))    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run && (cnt_q == CNT_W'(1));

  // R10: remaining time is frozen whenever the engine is not running
  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/fwc_sts_drive.sv
module fwc_sts_drive
  import fwc_pkg::*;
#(
  parameter int PULSE_CYC = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_we,
  input  sts_mode_e cfg_val,
  input  logic      busy,
  input  logic      fire,
  output sts_mode_e mode_o,
  output logic      sts_o
);

  localparam int PW = (PULSE_CYC < 1) ? 1 : $clog2(PULSE_CYC + 1);

  sts_mode_e      mode_q;
  logic [PW-1:0]  pcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= STS_LEVEL;
    else if (cfg_we) mode_q <= cfg_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pcnt_q <= '0;
    else if (fire)            pcnt_q <= PW'(PULSE_CYC);
    else if (pcnt_q != '0)    pcnt_q <= pcnt_q - 1'b1;
  end

  assign mode_o = mode_q;
  assign sts_o  = (mode_q == STS_LEVEL) ? !busy : (pcnt_q == '0);

  if (PULSE_CYC == 2) begin : g_chk2
    // R9: a pulse lasts at least two cycles
    assert_pulse_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q != STS_LEVEL) && $fell(sts_o)) |=> !sts_o);
    // R9: and no more than two
    assert_pulse_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q != STS_LEVEL) && !sts_o && $past(!sts_o) && !fire) |=> sts_o);
  end

endmodule

// File: rtl/flash_wsm_ctrl.sv
module flash_wsm_ctrl
  import fwc_pkg::*;
#(
  parameter int NBLK      = 8,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 32,
  parameter int LOCK_CYC  = 4,
  parameter int WAKE_CYC  = 3,
  parameter int PULSE_CYC = 2,
  parameter int BLK_W     = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_prog,
  input  logic             cmd_erase,
  input  logic             cmd_susp,
  input  logic             cmd_resume,
  input  logic             cmd_lock,
  input  logic             cmd_unlock_all,
  input  logic             cmd_cfg,
  input  logic [BLK_W-1:0] cmd_blk,
  input  logic [1:0]       cmd_cfg_mode,
  output logic             sts_o,
  output logic [3:0]       stat_o
);

  localparam int unsigned MAX_CYC = max3(PROG_CYC, ERASE_CYC, LOCK_CYC);
  localparam int CNT_W  = $clog2(MAX_CYC + 1);
  localparam int WAKE_W = (WAKE_CYC < 1) ? 1 : $clog2(WAKE_CYC + 1);

  fsm_e              state_q;
  op_e               op_q;
  logic [BLK_W-1:0]  blk_q;
  logic              lock_err_q, seq_err_q;
  logic [WAKE_W-1:0] wake_q;

  // named internal events
  logic      awake, any_cmd, lock_hit, t_done;
  logic      start_go, reject, cfg_we, susp_go, resume_go, seq_hit, pulse_fire;
  op_e       start_op;
  sts_mode_e mode_now;

  assign awake   = (wake_q == '0);
  assign any_cmd = cmd_prog | cmd_erase | cmd_susp | cmd_resume |
                   cmd_lock | cmd_unlock_all | cmd_cfg;

  // idle-time decode, fixed priority program > erase > lock > unlock > configure
  always_comb begin
    start_go = 1'b0;
    start_op = OP_PROG;
    reject   = 1'b0;
    cfg_we   = 1'b0;
    if ((state_q == ST_IDLE) && awake) begin
      if (cmd_prog || cmd_erase) begin
        if (lock_hit) reject = 1'b1;
        else begin
          start_go = 1'b1;
          start_op = cmd_prog ? OP_PROG : OP_ERASE;
        end
      end else if (cmd_lock) begin
        start_go = 1'b1;
        start_op = OP_LOCK;
      end else if (cmd_unlock_all) begin
        start_go = 1'b1;
        start_op = OP_CLRLK;
      end else if (cmd_cfg) begin
        cfg_we = 1'b1;
      end
    end
  end

  assign susp_go   = (state_q == ST_BUSY) && !t_done && cmd_susp && can_suspend(op_q);
  assign resume_go = (state_q == ST_SUSP) && cmd_resume;
  assign seq_hit   = ((state_q == ST_BUSY) && any_cmd && !susp_go) ||
                     ((state_q == ST_SUSP) && any_cmd && !resume_go);
  assign pulse_fire = t_done && wants_pulse(mode_now, op_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      op_q       <= OP_PROG;
      blk_q      <= '0;
      lock_err_q <= 1'b0;
      seq_err_q  <= 1'b0;
      wake_q     <= WAKE_W'(WAKE_CYC);
    end else begin
      if (!awake) wake_q <= wake_q - 1'b1;
      case (state_q)
        ST_IDLE: if (start_go) begin
          state_q <= ST_BUSY;
          op_q    <= start_op;
          blk_q   <= cmd_blk;
        end
        ST_BUSY: begin
          if (t_done)       state_q <= ST_IDLE;
          else if (susp_go) state_q <= ST_SUSP;
        end
        ST_SUSP: if (resume_go) state_q <= ST_BUSY;
        default: state_q <= ST_IDLE;
      endcase
      if (start_go) begin
        lock_err_q <= 1'b0;
        seq_err_q  <= 1'b0;
      end else begin
        if (reject)  lock_err_q <= 1'b1;
        if (seq_hit) seq_err_q  <= 1'b1;
      end
    end
  end

  fwc_lock_bank #(.NBLK(NBLK), .BLK_W(BLK_W)) u_locks (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (t_done && (op_q == OP_LOCK)),
    .set_idx   (blk_q),
    .clr_all   (t_done && (op_q == OP_CLRLK)),
    .rd_idx    (cmd_blk),
    .rd_locked (lock_hit)
  );

  fwc_op_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_go),
    .load_val (CNT_W'(op_len(start_op, PROG_CYC, ERASE_CYC, LOCK_CYC))),
    .run      (state_q == ST_BUSY),
    .done_o   (t_done)
  );

  fwc_sts_drive #(.PULSE_CYC(PULSE_CYC)) u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_val (sts_mode_e'(cmd_cfg_mode)),
    .busy    (state_q == ST_BUSY),
    .fire    (pulse_fire),
    .mode_o  (mode_now),
    .sts_o   (sts_o)
  );

  stat_t stat_w;
  always_comb begin
    stat_w.seq_err   = seq_err_q;
    stat_w.lock_err  = lock_err_q;
    stat_w.suspended = (state_q == ST_SUSP);
    stat_w.ready     = (state_q != ST_BUSY);
  end
  assign stat_o = stat_w;

  // R8: nothing starts inside the wake-up window
  assert_wake_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |-> (state_q == ST_IDLE));

  // R2: a request to a locked block leaves the engine idle with the error flag
  assert_locked_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && awake && (cmd_prog || cmd_erase) && lock_hit)
      |=> ((state_q == ST_IDLE) && lock_err_q));

  // R3: completion returns the engine to ready
  assert_done_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    t_done |=> stat_o[0]);

  // R12: work requests while running set the sequence error
  assert_busy_seq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_BUSY) && (cmd_prog || cmd_erase || cmd_lock)) |=> seq_err_q);

  // R5: an accepted suspend shows the suspended flag
  assert_susp_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    susp_go |=> (stat_o[1] && stat_o[0]));

endmodule

// File: tb/flash_wsm_ctrl_bench.sv
`timescale 1ns/100ps
module flash_wsm_ctrl_bench;

  // bench command codes
  localparam logic [2:0] C_NOP = 3'd0, C_PROG = 3'd1, C_ERASE = 3'd2, C_SUSP = 3'd3,
                         C_RES = 3'd4, C_LOCK = 3'd5, C_CLR = 3'd6, C_CFG = 3'd7;

  typedef struct packed {
    logic [2:0] cmd;
    logic [2:0] blk;
    logic [1:0] mode;
    logic [7:0] wt;
    logic [3:0] stat;
    logic       sts;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [0:NV-1] = '{
    '{C_LOCK, 3'd3, 2'd0, 8'd0,  4'b0000, 1'b0, 4'd4},  // R4 lock running
    '{C_NOP,  3'd0, 2'd0, 8'd3,  4'b0001, 1'b1, 4'd3},  // R3 lock takes 4 cycles
    '{C_PROG, 3'd3, 2'd0, 8'd0,  4'b0101, 1'b1, 4'd2},  // R2 program refused
    '{C_ERASE,3'd3, 2'd0, 8'd0,  4'b0101, 1'b1, 4'd2},  // R2 erase refused
    '{C_PROG, 3'd2, 2'd0, 8'd0,  4'b0000, 1'b0, 4'd3},  // R3 start clears errors
    '{C_PROG, 3'd5, 2'd0, 8'd0,  4'b1000, 1'b0, 4'd12}, // R12 command while busy
    '{C_SUSP, 3'd0, 2'd0, 8'd0,  4'b1011, 1'b1, 4'd5},  // R5 suspended
    '{C_NOP,  3'd0, 2'd0, 8'd5,  4'b1011, 1'b1, 4'd10}, // R10 stays suspended
    '{C_RES,  3'd0, 2'd0, 8'd0,  4'b1000, 1'b0, 4'd5},  // R5 resumed
    '{C_NOP,  3'd0, 2'd0, 8'd4,  4'b1000, 1'b0, 4'd10}, // R10 time was kept
    '{C_NOP,  3'd0, 2'd0, 8'd0,  4'b1001, 1'b1, 4'd10}, // R10 done after 8 running cycles
    '{C_CFG,  3'd0, 2'd3, 8'd0,  4'b1001, 1'b1, 4'd6},  // R6 pulse on either
    '{C_ERASE,3'd1, 2'd0, 8'd0,  4'b0000, 1'b1, 4'd6},  // R6 pin high while busy
    '{C_NOP,  3'd0, 2'd0, 8'd30, 4'b0000, 1'b1, 4'd3},  // R3 erase still running
    '{C_NOP,  3'd0, 2'd0, 8'd0,  4'b0001, 1'b0, 4'd9},  // R9 pulse cycle 1
    '{C_NOP,  3'd0, 2'd0, 8'd0,  4'b0001, 1'b0, 4'd9},  // R9 pulse cycle 2
    '{C_NOP,  3'd0, 2'd0, 8'd0,  4'b0001, 1'b1, 4'd9},  // R9 pulse over
    '{C_CLR,  3'd0, 2'd0, 8'd0,  4'b0000, 1'b1, 4'd1},  // R1 unlock all running
    '{C_NOP,  3'd0, 2'd0, 8'd3,  4'b0001, 1'b1, 4'd9},  // R9 no pulse for unlock
    '{C_PROG, 3'd3, 2'd0, 8'd0,  4'b0000, 1'b1, 4'd1},  // R1 block 3 free again
    '{C_NOP,  3'd0, 2'd0, 8'd6,  4'b0000, 1'b1, 4'd3},  // R3 program running
    '{C_NOP,  3'd0, 2'd0, 8'd0,  4'b0001, 1'b0, 4'd9},  // R9 program pulse
    '{C_NOP,  3'd0, 2'd0, 8'd0,  4'b0001, 1'b0, 4'd9},  // R9
    '{C_NOP,  3'd0, 2'd0, 8'd0,  4'b0001, 1'b1, 4'd9},  // R9
    '{C_CFG,  3'd0, 2'd1, 8'd0,  4'b0001, 1'b1, 4'd6},  // R6 pulse on erase only
    '{C_PROG, 3'd0, 2'd0, 8'd0,  4'b0000, 1'b1, 4'd6},  // R6
    '{C_NOP,  3'd0, 2'd0, 8'd7,  4'b0001, 1'b1, 4'd9},  // R9 program not selected
    '{C_SUSP, 3'd0, 2'd0, 8'd0,  4'b0001, 1'b1, 4'd11}, // R11 idle suspend ignored
    '{C_CFG,  3'd0, 2'd0, 8'd0,  4'b0001, 1'b1, 4'd6},  // R6 back to level
    '{C_LOCK, 3'd7, 2'd0, 8'd0,  4'b0000, 1'b0, 4'd4},  // R4 level low while busy
    '{C_SUSP, 3'd0, 2'd0, 8'd0,  4'b1000, 1'b0, 4'd11}, // R11 no suspend of lock
    '{C_NOP,  3'd0, 2'd0, 8'd2,  4'b1001, 1'b1, 4'd4},  // R4 high when done
    '{C_ERASE,3'd7, 2'd0, 8'd0,  4'b1101, 1'b1, 4'd2}   // R2 block 7 now locked
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_prog = 0, cmd_erase = 0, cmd_susp = 0, cmd_resume = 0;
  logic       cmd_lock = 0, cmd_unlock_all = 0, cmd_cfg = 0;
  logic [2:0] cmd_blk = '0;
  logic [1:0] cmd_cfg_mode = '0;
  logic       sts_o;
  logic [3:0] stat_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_wsm_ctrl u_flash_wsm_ctrl (
    .clk, .rst_n, .cmd_prog, .cmd_erase, .cmd_susp, .cmd_resume,
    .cmd_lock, .cmd_unlock_all, .cmd_cfg, .cmd_blk, .cmd_cfg_mode,
    .sts_o, .stat_o
  );

  task automatic check(input int req, input string what, input logic [3:0] act,
                       input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // called at a falling edge; drives one command across the next rising edge
  task automatic issue(input logic [2:0] c, input logic [2:0] b, input logic [1:0] m);
    cmd_blk      = b;
    cmd_cfg_mode = m;
    cmd_prog       = (c == C_PROG);
    cmd_erase      = (c == C_ERASE);
    cmd_susp       = (c == C_SUSP);
    cmd_resume     = (c == C_RES);
    cmd_lock       = (c == C_LOCK);
    cmd_unlock_all = (c == C_CLR);
    cmd_cfg        = (c == C_CFG);
    @(negedge clk);
    {cmd_prog, cmd_erase, cmd_susp, cmd_resume, cmd_lock, cmd_unlock_all, cmd_cfg} = '0;
  endtask

  task automatic release_and_wake();
    rst_n = 1'b1;
    repeat (3) issue(C_NOP, 3'd0, 2'd0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R7 state while held in reset
    check(7, "stat in reset", stat_o, 4'b0001);
    check(7, "sts in reset", {3'b0, sts_o}, 4'd1);

    // R8 command on first edge after release is ignored
    rst_n = 1'b1;
    issue(C_PROG, 3'd0, 2'd0);
    check(8, "stat after early program", stat_o, 4'b0001);
    check(8, "sts after early program", {3'b0, sts_o}, 4'd1);
    issue(C_NOP, 3'd0, 2'd0);
    issue(C_NOP, 3'd0, 2'd0);
    issue(C_PROG, 3'd0, 2'd0);
    check(8, "stat after wake program", stat_o, 4'b0000);
    check(4, "sts level busy", {3'b0, sts_o}, 4'd0);

    // R7 reset during an operation
    rst_n = 1'b0;
    #1;
    check(7, "stat reset mid-op", stat_o, 4'b0001);
    check(7, "sts reset mid-op", {3'b0, sts_o}, 4'd1);
    repeat (2) @(negedge clk);
    release_and_wake();

    // vector walk
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].cmd, VEC[i].blk, VEC[i].mode);
      repeat (int'(VEC[i].wt)) @(negedge clk);
      check(int'(VEC[i].req), $sformatf("vec %0d stat", i), stat_o, VEC[i].stat);
      check(int'(VEC[i].req), $sformatf("vec %0d sts", i), {3'b0, sts_o}, {3'b0, VEC[i].sts});
    end

    // R1 and R7: reset clears lock flags and the pulse mode
    issue(C_CFG, 3'd0, 2'd3);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    release_and_wake();
    issue(C_ERASE, 3'd7, 2'd0);
    check(1, "erase block 7 after reset", stat_o, 4'b0000);
    check(7, "level mode after reset", {3'b0, sts_o}, 4'd0);

    // R12 flag survives until next start, also from suspension
    issue(C_SUSP, 3'd0, 2'd0);
    issue(C_LOCK, 3'd1, 2'd0);
    check(12, "command while suspended", stat_o, 4'b1011);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule